// File: doc/BRIEF.md
# Serial Autobaud Lock and Echo Unit

This unit listens on an idle-high asynchronous receive line and works out the link's bit rate from the first character it sees. That character must be an uppercase `U` (0x55). The unit does not need to know the oscillator frequency or the bit rate in advance. It measures the character against its own clock and turns the result into a divisor, which is the number of clock cycles in one bit cell. That divisor then drives a built-in receiver and transmitter.

Once the rate is locked, the receiver frames each incoming 8N1 character and reports it on a one-cycle strobe with its data byte. The transmitter then sends the same byte back on the transmit line at the learned rate. Lock is held until reset. A measurement that is too short for reliable mid-bit sampling is thrown away, and so is one that runs past the range of the counter; in both cases the unit waits for a fresh `U`.

Top module: `uart_autobaud_echo`

## Requirements
- R1: After reset, `txd` is high, `locked` is low, `divisor` is 0 and `rx_valid` is low.
- R2: Frame the first character as 8N1: a low start bit, data LSB first, then a high stop bit. If it is 0x55 with a bit cell of P clock cycles, `locked` rises and `divisor` equals P. The count runs from the start-bit falling edge to the fourth falling edge after it (eight bit cells) and is then divided by 8.
- R3: A measurement that gives a divisor below `MIN_DIV` is rejected. `locked` stays low, and a later valid `U` still locks. While locked, `divisor` is never below `MIN_DIV`.
- R4: A measurement whose count reaches 2^(CNT_W+3)-1 cycles before the fourth falling edge is abandoned. The unit then re-arms for a new `U`.
- R5: The calibration character is neither reported nor echoed. `txd` stays high for as long as the unit is unlocked.
- R6: After lock, each character whose stop bit samples high gives exactly one single-cycle `rx_valid` pulse. `rx_data` holds the byte, with every bit sampled near the middle of its cell.
- R7: Each reported byte is sent back on `txd` as an 8N1 frame: a low start bit, data LSB first, then a high stop bit. Every bit lasts `divisor` cycles.
- R8: A character whose stop bit samples low is dropped. There is no `rx_valid` pulse and no echo.
- R9: A low pulse shorter than half a bit cell is treated as noise. No character is started from it.
- R10: Once set, `locked` and `divisor` keep their values until reset, whatever arrives on `rxd`, including a `U` at another rate.
- R11: Two characters received back to back are both echoed, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| txd | output | 1 | Serial transmit line carrying the echo, idle high |
| locked | output | 1 | Rate has been learned; sticky until reset |
| divisor | output | CNT_W | Measured clock cycles per bit cell |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Byte reported with `rx_valid` |

## Verification
Calibration is tried at several bit cells. These run from exactly `MIN_DIV` up to a slow rate, with odd and even values, which shows whether the divide-by-8 and the half-cell sampling point are both right. Each rate is followed by two back-to-back data bytes, using patterns such as all zeros, all ones, single set bits at either end and alternating bits. These separate a bit-order mistake or a lost second byte from a correct echo. Directed cases then add a `U` that is too fast, a line held low past the counter range, a short noise pulse, a low stop bit, and a second `U` at a new rate after lock. Each one shows whether the unit rejects or ignores that input, or wrongly acts on it.

// File: rtl/uart_autobaud_echo.sv
module uart_autobaud_echo #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  output logic             txd,
  output logic             locked,
  output logic [CNT_W-1:0] divisor,
  output logic             rx_valid,
  output logic [7:0]       rx_data
);
  localparam int               MW    = CNT_W + 3;
  localparam logic [MW-1:0]    M_MAX = '1;
  localparam logic [MW-1:0]    M_ONE = MW'(1);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] MIN_D = CNT_W'(MIN_DIV);

  // input synchroniser and falling-edge detect
  logic [1:0] sync;
  logic       rx_q;
  logic       rx_s;
  logic       fall;

  assign rx_s = sync[1];
  assign fall = rx_q & ~rx_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= 2'b11;
      rx_q <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      rx_q <= rx_s;
    end
  end

  // rate measurement: eight bit cells of the calibration character
  logic          meas_run;
  logic [1:0]    edges;
  logic [MW-1:0] mcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_run <= 1'b0;
      edges    <= 2'd0;
      mcnt     <= '0;
      locked   <= 1'b0;
      divisor  <= '0;
    end else if (!locked) begin
      if (!meas_run) begin
        if (fall) begin
          meas_run <= 1'b1;
          edges    <= 2'd0;
          mcnt     <= M_ONE;
        end
      end else if (fall) begin
        mcnt <= mcnt + M_ONE;
        if (edges == 2'd3) begin
          meas_run <= 1'b0;
          if (mcnt[MW-1:3] >= MIN_D) begin
            locked  <= 1'b1;
            divisor <= mcnt[MW-1:3];
          end
        end else begin
          edges <= edges + 2'd1;
        end
      end else if (mcnt == M_MAX) begin
        meas_run <= 1'b0;
      end else begin
        mcnt <= mcnt + M_ONE;
      end
    end
  end

  // receiver: mid-cell sampling, index 0 = start, 1..8 = data, 9 = stop
  logic             rx_busy;
  logic [3:0]       rx_idx;
  logic [CNT_W-1:0] rx_cnt;
  logic [7:0]       rx_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_busy  <= 1'b0;
      rx_idx   <= 4'd0;
      rx_cnt   <= '0;
      rx_sh    <= 8'd0;
      rx_valid <= 1'b0;
      rx_data  <= 8'd0;
    end else begin
      rx_valid <= 1'b0;
      if (!rx_busy) begin
        if (locked && fall) begin
          rx_busy <= 1'b1;
          rx_idx  <= 4'd0;
          rx_cnt  <= divisor >> 1;
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - ONE;
      end else begin
        rx_cnt <= divisor - ONE;
        rx_idx <= rx_idx + 4'd1;
        if (rx_idx == 4'd0) begin
          if (rx_s) rx_busy <= 1'b0;
        end else if (rx_idx == 4'd9) begin
          rx_busy <= 1'b0;
          if (rx_s) begin
            rx_valid <= 1'b1;
            rx_data  <= rx_sh;
          end
        end else begin
          rx_sh <= {rx_s, rx_sh[7:1]};
        end
      end
    end
  end

  // transmitter with a single pending byte
  logic             tx_busy;
  logic [9:0]       tx_sh;
  logic [3:0]       tx_left;
  logic [CNT_W-1:0] tx_cnt;
  logic             pend;
  logic [7:0]       pend_d;

  assign txd = tx_sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_left <= 4'd0;
      tx_cnt  <= '0;
      pend    <= 1'b0;
      pend_d  <= 8'd0;
    end else begin
      if (tx_busy) begin
        if (tx_cnt != '0) begin
          tx_cnt <= tx_cnt - ONE;
        end else begin
          tx_cnt  <= divisor - ONE;
          tx_sh   <= {1'b1, tx_sh[9:1]};
          tx_left <= tx_left - 4'd1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end
      end else if (pend) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, pend_d, 1'b0};
        tx_cnt  <= divisor - ONE;
        tx_left <= 4'd10;
        pend    <= 1'b0;
      end
      if (rx_valid) begin
        pend   <= 1'b1;
        pend_d <= rx_data;
      end
    end
  end
endmodule

// File: rtl/uart_autobaud_echo_chk.sv
module uart_autobaud_echo_chk #(
  parameter int CNT_W   = 16,
  parameter int MIN_DIV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txd,
  input logic             locked,
  input logic [CNT_W-1:0] divisor,
  input logic             rx_valid
);
  localparam logic [CNT_W-1:0] MIN_D = CNT_W'(MIN_DIV);

  AST_UNLOCKED_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !locked |-> divisor == '0);        // R1
  AST_DIV_MIN:           assert property (@(posedge clk) disable iff (!rst_n) locked |-> divisor >= MIN_D);       // R3
  AST_TX_QUIET:          assert property (@(posedge clk) disable iff (!rst_n) !locked |-> txd);                    // R5
  AST_RXV_PULSE:         assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid);             // R6
  AST_RXV_LOCKED:        assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> locked);                // R6
  AST_LOCK_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked);                  // R10
  AST_DIV_FROZEN:        assert property (@(posedge clk) disable iff (!rst_n) locked |=> $stable(divisor));        // R10
endmodule

bind uart_autobaud_echo uart_autobaud_echo_chk #(.CNT_W(CNT_W), .MIN_DIV(MIN_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .locked(locked), .divisor(divisor), .rx_valid(rx_valid)
);

// File: tb/uart_autobaud_echo_bench.sv
module uart_autobaud_echo_bench;
  localparam int CW = 10;
  localparam int MD = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rxd = 1'b1;
  logic          txd;
  logic          locked;
  logic [CW-1:0] divisor;
  logic          rx_valid;
  logic [7:0]    rx_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_autobaud_echo #(.CNT_W(CW), .MIN_DIV(MD)) u_uart_autobaud_echo (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd), .locked(locked),
    .divisor(divisor), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  // port monitors: received-byte log and count of txd falling edges
  logic [7:0] rx_log [64];
  int   rx_n = 0;
  int   tx_falls = 0;
  logic txd_q = 1'b1;

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_log[rx_n % 64] = rx_data;
      rx_n = rx_n + 1;
    end
    if (txd_q && !txd) tx_falls = tx_falls + 1;
    txd_q = txd;
  end

  // {bit cell, first byte, second byte}
  localparam logic [31:0] VEC [5] = '{
    {16'd4,  8'hA5, 8'h00},
    {16'd5,  8'h3C, 8'hFF},
    {16'd7,  8'h01, 8'h80},
    {16'd16, 8'h55, 8'hAA},
    {16'd33, 8'h7E, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_byte(input int p, input logic [7:0] b, input logic stop);
    rxd = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (p) @(negedge clk);
    end
    rxd = stop;
    repeat (p) @(negedge clk);
    rxd = 1'b1;
  endtask

  task automatic recv_echo(input int p, output logic [7:0] b, output logic ok);
    int t = 0;
    b = 8'hxx;
    ok = 1'b0;
    while (txd !== 1'b0 && t < 40 * p + 200) begin
      @(negedge clk);
      t++;
    end
    if (txd === 1'b0) begin
      repeat (p / 2) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
        repeat (p) @(negedge clk);
        b[i] = txd;
      end
      repeat (p) @(negedge clk);
      ok = (txd === 1'b1);
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int rx0, tf0;
    logic [7:0] e0, e1;
    logic ok0, ok1;

    // vector table: calibrate at a rate, then two back-to-back bytes
    for (int v = 0; v < 5; v++) begin
      int p;
      logic [7:0] b0, b1;
      p = int'(VEC[v][31:16]);
      b0 = VEC[v][15:8];
      b1 = VEC[v][7:0];
      do_reset();
      chk("R1 txd", 32'(txd), 32'd1);
      chk("R1 locked", 32'(locked), 32'd0);
      chk("R1 divisor", 32'(divisor), 32'd0);
      chk("R1 rx_valid", 32'(rx_valid), 32'd0);
      rx0 = rx_n;
      tf0 = tx_falls;
      send_byte(p, 8'h55, 1'b1);
      repeat (2 * p) @(negedge clk);
      chk("R2 locked", 32'(locked), 32'd1);
      chk("R2 divisor", 32'(divisor), 32'(p));
      chk("R5 no strobe for U", 32'(rx_n - rx0), 32'd0);
      chk("R5 no echo of U", 32'(tx_falls - tf0), 32'd0);
      rx0 = rx_n;
      fork
        begin send_byte(p, b0, 1'b1); send_byte(p, b1, 1'b1); end
        begin recv_echo(p, e0, ok0); recv_echo(p, e1, ok1); end
      join
      chk("R6 strobe count", 32'(rx_n - rx0), 32'd2);
      chk("R6 first byte", 32'(rx_log[rx0 % 64]), 32'(b0));
      chk("R6 second byte", 32'(rx_log[(rx0 + 1) % 64]), 32'(b1));
      chk("R7 first echo", {23'd0, ok0, e0}, {23'd0, 1'b1, b0});
      chk("R11 second echo", {23'd0, ok1, e1}, {23'd0, 1'b1, b1});
    end

    // R3: too fast, rejected, then a valid U locks
    do_reset();
    send_byte(3, 8'h55, 1'b1);
    repeat (20) @(negedge clk);
    chk("R3 fast U rejected", 32'(locked), 32'd0);
    send_byte(10, 8'h55, 1'b1);
    repeat (20) @(negedge clk);
    chk("R3 re-armed lock", 32'(locked), 32'd1);
    chk("R3 re-armed divisor", 32'(divisor), 32'd10);

    // R9: short low pulse is noise
    rx0 = rx_n;
    tf0 = tx_falls;
    rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (150) @(negedge clk);
    chk("R9 glitch no strobe", 32'(rx_n - rx0), 32'd0);
    chk("R9 glitch no echo", 32'(tx_falls - tf0), 32'd0);

    // R8: low stop bit drops the byte
    send_byte(10, 8'h96, 1'b0);
    repeat (150) @(negedge clk);
    chk("R8 framing no strobe", 32'(rx_n - rx0), 32'd0);
    chk("R8 framing no echo", 32'(tx_falls - tf0), 32'd0);

    // receiver still healthy afterwards
    fork
      send_byte(10, 8'h5A, 1'b1);
      recv_echo(10, e0, ok0);
    join
    chk("R6 after errors", 32'(rx_log[rx0 % 64]), 32'h5A);
    chk("R7 after errors", {23'd0, ok0, e0}, {23'd0, 1'b1, 8'h5A});

    // R10: a U at another rate changes nothing
    send_byte(20, 8'h55, 1'b1);
    repeat (600) @(negedge clk);
    chk("R10 locked held", 32'(locked), 32'd1);
    chk("R10 divisor held", 32'(divisor), 32'd10);

    // R4: line held low past counter range, then a valid U
    do_reset();
    rxd = 1'b0;
    repeat (9000) @(negedge clk);
    rxd = 1'b1;
    repeat (20) @(negedge clk);
    chk("R4 overflow no lock", 32'(locked), 32'd0);
    chk("R4 overflow divisor", 32'(divisor), 32'd0);
    send_byte(6, 8'h55, 1'b1);
    repeat (20) @(negedge clk);
    chk("R4 re-armed lock", 32'(locked), 32'd1);
    chk("R4 re-armed divisor", 32'(divisor), 32'd6);

    summary();
  end
endmodule